// File: doc/BRIEF.md
# AUX Request Header Framer

This block turns a single DisplayPort AUX request into the byte sequence that a transmit buffer holds before the request goes out on the wire. When a request strobe is accepted, the block writes a packed command/address header into the buffer. If the request carries a length, it then writes a length byte. For write-type requests it continues with the payload bytes, which it pulls from a valid/ready byte stream. Once the last byte has been stored, it issues a one-cycle go pulse together with the total number of bytes to transmit.

The buffer side is a simple byte-write port. The write address starts at zero and steps by one for every stored byte. The block is busy for the whole duration of a frame and ignores new strobes until the frame is done. A request longer than the payload limit is refused with an error pulse and is never framed. Line coding and serialization are handled elsewhere.

Top module: `aux_req_framer`

## Requirements
- R1: Buffer byte 0 is the 4-bit command in bits 7:4 and request address bits 19:16 in bits 3:0.
- R2: Buffer byte 1 is address bits 15:8 and buffer byte 2 is address bits 7:0.
- R3: With a non-zero request length, buffer byte 3 holds the length minus one. With a zero length, no length byte is written.
- R4: The reported byte count is 3 for a zero-length request and 4 otherwise, plus the length for write-type requests. It equals the number of buffer writes made and is valid while go is high.
- R5: Action codes are read=0, write=1, read with middle-of-transaction=2, write with middle-of-transaction=3, and req_i2c=1 selects I2C-over-AUX. Payload is sent only for native write (code 1), I2C write (code 1) and I2C write with middle-of-transaction (code 3). For every other combination pl_ready stays low and no payload byte is written.
- R6: Buffer writes use addresses 0, 1, 2, ... in order, one per written byte. Payload bytes follow the header in stream order, and a byte is taken only when pl_valid and pl_ready are both high, so stalls in the stream are tolerated.
- R7: go is a single-cycle pulse issued after the final byte of the frame has been written, once per accepted request.
- R8: A strobe whose length exceeds MAX_LEN (16) gives a one-cycle len_err pulse. Such a request makes no buffer write and no go pulse, and busy stays low.
- R9: busy rises in the cycle after an accepted strobe and stays high through the go cycle. Strobes that arrive while busy is high are ignored.
- R10: Out of reset, busy, go, buf_we, pl_ready and len_err are low and byte_cnt is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_cmd | input | 4 | Command nibble |
| req_addr | input | 20 | Request address |
| req_i2c | input | 1 | 1 = I2C-over-AUX, 0 = native |
| req_action | input | 2 | Action code (see R5) |
| req_len | input | LEN_W (8) | Payload length in bytes |
| pl_data | input | 8 | Payload stream byte |
| pl_valid | input | 1 | Payload byte available |
| pl_ready | output | 1 | Block takes a payload byte this cycle |
| buf_we | output | 1 | Transmit buffer write enable |
| buf_addr | output | CNT_W (5) | Transmit buffer byte index |
| buf_wdata | output | 8 | Transmit buffer write data |
| byte_cnt | output | CNT_W (5) | Total bytes to send for the last frame |
| go | output | 1 | Start-transmit pulse |
| busy | output | 1 | Frame in progress |
| len_err | output | 1 | Oversized request refused |

## Verification
The bench targets three boundaries. The first is zero length: a design that emits the length byte anyway gives a count of 4 and a stray byte 3. The second is the largest legal payload against one byte beyond it: an off-by-one limit check would either refuse 16 bytes or frame 17. The third is the native write-with-middle-of-transaction combination, which a design that keys on the action code alone would wrongly fill with payload. Stalled payload streams catch designs that advance the index without a handshake. A strobe injected mid-frame catches designs that restart or corrupt the header while busy.

// File: rtl/aux_framer_pkg.sv
// Package: shared types for the AUX request framer.
// Assumes action codes are fixed by the request source (see brief, R5).
package aux_framer_pkg;

    typedef enum logic [1:0] {
        ACT_READ      = 2'd0,
        ACT_WRITE     = 2'd1,
        ACT_READ_MOT  = 2'd2,
        ACT_WRITE_MOT = 2'd3
    } act_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HDR  = 2'd1,
        ST_PAY  = 2'd2,
        ST_GO   = 2'd3
    } fst_e;

    typedef struct packed {
        logic [3:0]  cmd;
        logic [19:0] addr;
        logic        i2c;
        act_e        act;
    } req_hdr_t;

endpackage

// File: rtl/aux_write_class.sv
// Module: aux_write_class
// Decides whether a request carries payload bytes. Only native write,
// I2C write and I2C write-with-middle-of-transaction qualify.
// Assumes: purely combinational, inputs stable while framing.
module aux_write_class
    import aux_framer_pkg::*;
(
    input  logic i2c,
    input  act_e act,
    output logic is_wr
);

    // Classify the transfer type and action pair.
    always_comb begin
        if (i2c) begin
            is_wr = (act == ACT_WRITE) || (act == ACT_WRITE_MOT);
        end else begin
            is_wr = (act == ACT_WRITE);
        end
    end

endmodule

// File: rtl/aux_hdr_pack.sv
// Module: aux_hdr_pack
// Produces the header/length byte for a given buffer index, the index of
// the last non-payload byte, and the total frame byte count.
// Assumes len has already been checked against the payload limit.
module aux_hdr_pack
    import aux_framer_pkg::*;
#(
    parameter int LEN_W = 8,
    parameter int CNT_W = 5
) (
    input  req_hdr_t         hdr,
    input  logic [LEN_W-1:0] len,
    input  logic             is_wr,
    input  logic [CNT_W-1:0] idx,
    output logic [7:0]       hdr_byte,
    output logic [CNT_W-1:0] hdr_last,
    output logic [CNT_W-1:0] total
);

    localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

    logic             has_len;
    logic [CNT_W-1:0] len_c;
    logic [LEN_W-1:0] len_m1;

    // Derive the length-related terms.
    always_comb begin
        has_len = (len != '0);
        len_c   = CNT_W'(len);
        len_m1  = len - LEN_ONE;
    end

    // Select the header byte for the current index.
    always_comb begin
        case (idx)
            CNT_W'(0): hdr_byte = {hdr.cmd, hdr.addr[19:16]};
            CNT_W'(1): hdr_byte = hdr.addr[15:8];
            CNT_W'(2): hdr_byte = hdr.addr[7:0];
            default:   hdr_byte = 8'(len_m1);
        endcase
    end

    // Compute the last header index and the frame byte count.
    always_comb begin
        hdr_last = has_len ? CNT_W'(3) : CNT_W'(2);
        total    = (has_len ? CNT_W'(4) : CNT_W'(3)) + (is_wr ? len_c : '0);
    end

endmodule

// File: rtl/aux_frame_seq.sv
// Module: aux_frame_seq
// Sequencer: walks the header bytes, then the payload bytes under a
// valid/ready handshake, then raises go for one cycle.
// Assumes start is only asserted while idle and len is within limits.
module aux_frame_seq
    import aux_framer_pkg::*;
#(
    parameter int LEN_W = 8,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             is_wr,
    input  logic [LEN_W-1:0] len,
    input  logic [CNT_W-1:0] hdr_last,
    input  logic             pl_valid,
    output logic             pl_ready,
    output logic             wr_en,
    output logic [CNT_W-1:0] idx,
    output logic             go,
    output logic             busy
);

    localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

    fst_e             st;
    logic [LEN_W-1:0] pcnt;
    logic             pay_last;

    // Detect the final payload byte.
    always_comb begin
        pay_last = (pcnt == (len - LEN_ONE));
    end

    // State, index and payload counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            idx  <= '0;
            pcnt <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        st   <= ST_HDR;
                        idx  <= '0;
                        pcnt <= '0;
                    end
                end
                ST_HDR: begin
                    idx <= idx + CNT_W'(1);
                    if (idx == hdr_last) begin
                        st <= (is_wr && (len != '0)) ? ST_PAY : ST_GO;
                    end
                end
                ST_PAY: begin
                    if (pl_valid) begin
                        idx  <= idx + CNT_W'(1);
                        pcnt <= pcnt + LEN_ONE;
                        if (pay_last) begin
                            st <= ST_GO;
                        end
                    end
                end
                default: begin
                    st <= ST_IDLE;
                end
            endcase
        end
    end

    // Decode outputs from the state.
    always_comb begin
        pl_ready = (st == ST_PAY);
        wr_en    = (st == ST_HDR) || ((st == ST_PAY) && pl_valid);
        go       = (st == ST_GO);
        busy     = (st != ST_IDLE);
    end

    p_go_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> !go);

    p_go_ends_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> !busy);

    p_payload_write_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pl_ready |-> is_wr);

    p_write_in_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> busy);

endmodule

// File: rtl/aux_req_framer.sv
// Module: aux_req_framer (top)
// Accepts one AUX request at a time, checks its length, captures it and
// drives the header/length/payload bytes into a transmit buffer, then
// pulses go with the byte count.
// Assumes the payload source holds pl_data stable while pl_valid is high
// and pl_ready is low.
module aux_req_framer
    import aux_framer_pkg::*;
#(
    parameter int MAX_LEN = 16,
    parameter int LEN_W   = 8,
    parameter int CNT_W   = $clog2(MAX_LEN + 5)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [3:0]       req_cmd,
    input  logic [19:0]      req_addr,
    input  logic             req_i2c,
    input  logic [1:0]       req_action,
    input  logic [LEN_W-1:0] req_len,
    input  logic [7:0]       pl_data,
    input  logic             pl_valid,
    output logic             pl_ready,
    output logic             buf_we,
    output logic [CNT_W-1:0] buf_addr,
    output logic [7:0]       buf_wdata,
    output logic [CNT_W-1:0] byte_cnt,
    output logic             go,
    output logic             busy,
    output logic             len_err
);

    localparam logic [LEN_W-1:0] LEN_LIMIT = LEN_W'(MAX_LEN);

    req_hdr_t         req_q;
    logic [LEN_W-1:0] len_q;
    logic             len_bad;
    logic             accept;
    logic             is_wr;
    logic [7:0]       hdr_byte;
    logic [CNT_W-1:0] hdr_last;
    logic [CNT_W-1:0] total;
    logic [CNT_W-1:0] cnt_q;
    logic             err_q;

    // Qualify an incoming strobe.
    always_comb begin
        len_bad = (req_len > LEN_LIMIT);
        accept  = req_valid && !busy && !len_bad;
    end

    // Capture the request on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= '0;
            len_q <= '0;
        end else if (accept) begin
            req_q <= '{cmd: req_cmd, addr: req_addr, i2c: req_i2c,
                       act: act_e'(req_action)};
            len_q <= req_len;
        end
    end

    // Flag an oversized request for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            err_q <= req_valid && !busy && len_bad;
        end
    end

    // Latch the frame byte count while the first header byte is written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (buf_we && (buf_addr == '0)) begin
            cnt_q <= total;
        end
    end

    aux_write_class u_class (
        .i2c   (req_q.i2c),
        .act   (req_q.act),
        .is_wr (is_wr)
    );

    aux_hdr_pack #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_pack (
        .hdr      (req_q),
        .len      (len_q),
        .is_wr    (is_wr),
        .idx      (buf_addr),
        .hdr_byte (hdr_byte),
        .hdr_last (hdr_last),
        .total    (total)
    );

    aux_frame_seq #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .is_wr    (is_wr),
        .len      (len_q),
        .hdr_last (hdr_last),
        .pl_valid (pl_valid),
        .pl_ready (pl_ready),
        .wr_en    (buf_we),
        .idx      (buf_addr),
        .go       (go),
        .busy     (busy)
    );

    // Drive the buffer data and the status outputs.
    always_comb begin
        buf_wdata = pl_ready ? pl_data : hdr_byte;
        byte_cnt  = cnt_q;
        len_err   = err_q;
    end

    p_count_matches_writes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> (buf_addr == byte_cnt));

    p_err_no_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
        len_err |-> (!busy && !buf_we));

    p_busy_needs_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));

endmodule

// File: tb/aux_req_framer_test.sv
`timescale 1ns/1ps
module aux_req_framer_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [3:0] req_cmd = '0;
    logic [19:0] req_addr = '0;
    logic       req_i2c = 1'b0;
    logic [1:0] req_action = '0;
    logic [7:0] req_len = '0;
    logic [7:0] pl_data;
    logic       pl_valid;
    logic       pl_ready;
    logic       buf_we;
    logic [4:0] buf_addr;
    logic [7:0] buf_wdata;
    logic [4:0] byte_cnt;
    logic       go;
    logic       busy;
    logic       len_err;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] pay [0:31];
    logic [7:0] cap [0:31];
    int feed_len = 0;
    int pl_ptr = 0;
    bit stall = 1'b0;
    bit phase = 1'b0;
    int wr_n = 0;
    int go_n = 0;
    int err_n = 0;
    int rdy_n = 0;
    int go_cnt = 0;

    always #2 clk = ~clk;

    aux_req_framer uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_i2c(req_i2c), .req_action(req_action),
        .req_len(req_len), .pl_data(pl_data), .pl_valid(pl_valid),
        .pl_ready(pl_ready), .buf_we(buf_we), .buf_addr(buf_addr),
        .buf_wdata(buf_wdata), .byte_cnt(byte_cnt), .go(go), .busy(busy),
        .len_err(len_err)
    );

    assign pl_valid = (pl_ptr < feed_len) && (!stall || phase);
    assign pl_data  = pay[pl_ptr[4:0]];

    always @(posedge clk) begin
        phase <= ~phase;
        if (req_valid && !busy) pl_ptr <= 0;
        else if (pl_valid && pl_ready) pl_ptr <= pl_ptr + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor buffer writes, go pulses and error pulses away from the edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (buf_we) begin
                if (int'(buf_addr) != wr_n) begin
                    n_chk++; n_fail++;
                    $display("FAIL R6 write order actual=%0h expected=%0h", buf_addr, wr_n);
                end
                cap[buf_addr] = buf_wdata;
                wr_n++;
            end
            if (pl_ready) rdy_n++;
            if (go) begin go_n++; go_cnt = int'(byte_cnt); end
            if (len_err) err_n++;
        end
    end

    task automatic frame(input logic [3:0] cmd, input logic [19:0] addr,
                         input bit i2c, input logic [1:0] act, input int len,
                         input bit stl, input bit inject);
        logic [7:0] exp [0:31];
        int n;
        bit wr;
        wr = (!i2c && act == 2'd1) || (i2c && (act == 2'd1 || act == 2'd3));
        exp[0] = {cmd, addr[19:16]};
        exp[1] = addr[15:8];
        exp[2] = addr[7:0];
        n = 3;
        if (len != 0) begin exp[3] = 8'(len - 1); n = 4; end
        for (int i = 0; i < len; i++) pay[i] = 8'(8'h3C ^ (i * 29) ^ addr[7:0]);
        if (wr) begin
            for (int i = 0; i < len; i++) exp[n + i] = pay[i];
            n = n + len;
        end
        @(negedge clk);
        wr_n = 0; go_n = 0; rdy_n = 0; go_cnt = 0;
        feed_len = len; stall = stl;
        req_cmd = cmd; req_addr = addr; req_i2c = i2c; req_action = act;
        req_len = 8'(len); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R9 busy after strobe", busy, 1);
        if (inject) begin
            @(negedge clk);
            req_cmd = ~cmd; req_addr = ~addr; req_len = 8'd0; req_action = 2'd0;
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
        end
        for (int k = 0; k < 200 && go_n == 0; k++) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(busy == 1'b0, "R9 busy after go", busy, 0);
        chk(go_n == 1, "R7 go pulse count", go_n, 1);
        chk(go_cnt == n, "R4 byte count", go_cnt, n);
        chk(wr_n == n, "R4 writes made", wr_n, n);
        if (!wr) chk(rdy_n == 0, "R5 no payload pull", rdy_n, 0);
        for (int i = 0; i < n; i++) begin
            if (i == 0)                  chk(cap[i] == exp[i], "R1 byte0", cap[i], exp[i]);
            else if (i < 3)              chk(cap[i] == exp[i], "R2 address byte", cap[i], exp[i]);
            else if (i == 3 && len != 0) chk(cap[i] == exp[i], "R3 length byte", cap[i], exp[i]);
            else                         chk(cap[i] == exp[i], "R6 payload byte", cap[i], exp[i]);
        end
    endtask

    task automatic t_reset;
        chk(busy == 0 && go == 0 && buf_we == 0, "R10 reset control", {busy, go, buf_we}, 0);
        chk(pl_ready == 0 && len_err == 0, "R10 reset flags", {pl_ready, len_err}, 0);
        chk(byte_cnt == 0, "R10 reset count", byte_cnt, 0);
    endtask

    task automatic t_zero_len;      // R3 R4: no length byte, count 3
        frame(4'h9, 20'hA5C3E, 1'b0, 2'd0, 0, 1'b0, 1'b0);
        frame(4'h8, 20'h00100, 1'b0, 2'd1, 0, 1'b0, 1'b0);
    endtask

    task automatic t_reads;         // R5: reads send no payload
        frame(4'h9, 20'h12345, 1'b0, 2'd0, 5, 1'b0, 1'b0);
        frame(4'h5, 20'h00050, 1'b1, 2'd2, 2, 1'b0, 1'b0);
        frame(4'h8, 20'hF0F0F, 1'b0, 2'd3, 3, 1'b0, 1'b0);
    endtask

    task automatic t_writes;        // R5 R6: payload with and without stalls
        frame(4'h8, 20'hB0012, 1'b0, 2'd1, 4, 1'b0, 1'b0);
        frame(4'h4, 20'h00050, 1'b1, 2'd3, 3, 1'b1, 1'b0);
    endtask

    task automatic t_max_len;       // R4 R8 boundary: 16 accepted
        frame(4'h0, 20'h7FFFF, 1'b1, 2'd1, 16, 1'b1, 1'b0);
    endtask

    task automatic t_too_long;      // R8: 17 and 255 refused
        for (int j = 0; j < 2; j++) begin
            @(negedge clk);
            wr_n = 0; go_n = 0; err_n = 0;
            req_len = (j == 0) ? 8'd17 : 8'd255; req_action = 2'd1; req_i2c = 1'b0;
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            chk(busy == 1'b0, "R8 busy stays low", busy, 0);
            repeat (5) @(negedge clk);
            chk(err_n == 1, "R8 error pulse", err_n, 1);
            chk(wr_n == 0 && go_n == 0, "R8 no frame", wr_n + go_n, 0);
        end
    endtask

    task automatic t_busy_ignore;   // R9: strobe mid-frame has no effect
        frame(4'h8, 20'h3C3C3, 1'b0, 2'd1, 8, 1'b1, 1'b1);
        repeat (6) @(negedge clk);
        chk(go_n == 1 && wr_n == 12, "R9 no second frame", go_n * 100 + wr_n, 112);
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R7 watchdog expired actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_zero_len();
        t_reads();
        t_writes();
        t_max_len();
        t_too_long();
        t_busy_ignore();
        frame(4'h1, 20'h00001, 1'b1, 2'd1, 1, 1'b0, 1'b0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule